// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Engine

This block turns per-vector interrupt requests from device logic into address/data messages. Each of `NVEC` vectors owns a four-word entry in a memory-mapped table: a 64-bit target address, a 32-bit payload and a control word whose bit 0 masks the vector. A bit array that records requests held back by masking follows the table in the same region. A separate 16-bit control word carries a global enable (bit 15), a function-wide mask (bit 14) and a read-only vector-count field.

A request that arrives while the vector, the function or the whole block is blocked is remembered in the pending array and is not lost. When the blocking condition goes away, either through a write to the vector's table entry or through a control-word change, every remembered vector that is now open is delivered, lowest index first. Messages leave on a valid/ready channel and stay stable until they are accepted.

Top module: `msix_engine`

## Requirements
- R1: After reset the table and pending array read as zero, `msg_valid` is low, and the control word reads enable 0, function mask 0 and count field `NVEC-1` (0x001F for 32 vectors).
- R2: Vector v's entry starts at byte 16*v and holds, in word order, address low, address high, payload and vector control. A full-word write to any table word reads back unchanged.
- R3: A delivered message carries `msg_addr = {address high, address low[31:2], 2'b00}` and `msg_data` equal to the payload word.
- R4: A rising request on a vector whose control bit 0 is set, or while the function mask is set, or while enable is clear, sends nothing and sets that vector's pending bit. The pending array starts at byte 16*NVEC. Vector i appears in 32-bit word i/32, bit i mod 32 (byte i/8, bit i mod 8).
- R5: A rising request on an open vector delivers exactly one message, and its pending bit then reads 0.
- R6: A request line held high produces one message only. Only the low-to-high change counts.
- R7: A table write that clears the mask of a pending vector delivers that vector's message.
- R8: Clearing the function mask, or setting enable, delivers every pending open vector in ascending index order.
- R9: Register writes that land in the pending array are ignored, and so is any write without all four byte enables.
- R10: The region spans 16*NVEC plus ceil(NVEC/8) bytes rounded up to 4096. Inside it, words past the pending array read 0. Past the region, and for any access without all four byte enables, reads return all ones.
- R11: Only control bits 15 and 14 are writable. Bits 13:11 read 0 and bits 10:0 read `NVEC-1` whatever is written.
- R12: While `msg_valid` is high and `msg_ready` low, `msg_addr` and `msg_data` hold. A request for a vector whose message is still waiting does not change that message. It only marks the vector pending, which yields one further message carrying the table contents at the time that message starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write when high |
| reg_be | input | 4 | Byte enables; only 4'hF is a legal access |
| reg_addr | input | AW | Byte address inside the region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read value |
| irq | input | NVEC | Per-vector request lines, rising-edge sensitive |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The assertions assume that `msg_ready` is a plain level that the consumer may hold low for any length of time. They also assume that request lines are synchronous to `clk`, so a rising edge is one sampled low followed by one sampled high. The stimulus changes every input on the falling clock edge only. It holds each request pulse high for two cycles and low for at least two, and it keeps `msg_ready` low for long stretches to create a waiting message. All accesses to the register port are single cycles. Partial byte enables are used only where the requirement calls for them.

// File: rtl/msix_engine.sv
module msix_engine #(
  parameter int NVEC = 32,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_req,
  input  logic            reg_we,
  input  logic [3:0]      reg_be,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            cfg_we,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic [NVEC-1:0] irq,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int TBL_BYTES = NVEC * 16;
  localparam int PBA_BYTES = (NVEC + 7) / 8;
  localparam int REGION    = ((TBL_BYTES + PBA_BYTES + 4095) / 4096) * 4096;
  localparam int PWORDS    = (NVEC + 31) / 32;
  localparam int NWORDS    = NVEC * 4;
  localparam int VW        = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int TW        = VW + 2;

  logic [31:0]          tbl [NWORDS];
  logic [NVEC-1:0]      pend, pend_nx, irq_q, rise, vmask, open_v;
  logic [PWORDS*32-1:0] pend_pad;
  logic                 en, fm, found, launch, wr_ok;
  logic [VW-1:0]        sel;
  logic [AW-1:0]        poff;
  logic [TW-1:0]        widx;

  assign rise      = irq & ~irq_q;
  assign cfg_rdata = {en, fm, 3'b000, 11'(NVEC - 1)};
  assign wr_ok     = reg_req && reg_we && (reg_be == 4'hF) && (reg_addr < AW'(TBL_BYTES));
  assign widx      = TW'(reg_addr >> 2);
  assign poff      = reg_addr - AW'(TBL_BYTES);
  assign launch    = found && (!msg_valid || msg_ready);

  always_comb begin
    for (int v = 0; v < NVEC; v++) vmask[v] = tbl[v*4+3][0];
    open_v = pend & ~vmask & {NVEC{en && !fm}};
    found = 1'b0;
    sel = '0;
    for (int v = NVEC - 1; v >= 0; v--)
      if (open_v[v]) begin
        found = 1'b1;
        sel = VW'(v);
      end
    pend_nx = pend;
    if (launch) pend_nx[sel] = 1'b0;
    pend_nx = pend_nx | rise;
    pend_pad = '0;
    pend_pad[NVEC-1:0] = pend;
  end

  always_comb begin
    reg_rdata = '1;
    if (reg_be == 4'hF) begin
      if (reg_addr < AW'(TBL_BYTES)) reg_rdata = tbl[widx];
      else if (reg_addr < AW'(REGION)) begin
        reg_rdata = '0;
        for (int w = 0; w < PWORDS; w++)
          if (poff[AW-1:2] == (AW-2)'(w)) reg_rdata = pend_pad[w*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) tbl[i] <= '0;
      pend      <= '0;
      irq_q     <= '0;
      en        <= 1'b0;
      fm        <= 1'b0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_q <= irq;
      pend  <= pend_nx;
      if (cfg_we) begin
        en <= cfg_wdata[15];
        fm <= cfg_wdata[14];
      end
      if (wr_ok) tbl[widx] <= reg_wdata;
      if (launch) begin
        msg_valid <= 1'b1;
        msg_addr  <= {tbl[{sel, 2'd1}], tbl[{sel, 2'd0}][31:2], 2'b00};
        msg_data  <= tbl[{sel, 2'd2}];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_pend_grows_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend) > $past($countones(pend)) |-> $past(|(irq & ~irq_q)));

  p_start_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en && !fm));

  p_drop_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && (pend == '0) |=> !msg_valid);
endmodule

// File: tb/tb_msix_engine.sv
module tb_msix_engine;
  localparam int NVEC = 32;
  localparam int AW   = 16;

  logic            clk = 0, rst_n = 0;
  logic            reg_req = 0, reg_we = 0, cfg_we = 0, msg_ready = 0;
  logic [3:0]      reg_be = 4'hF;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0, reg_rdata, msg_data;
  logic [15:0]     cfg_wdata = '0, cfg_rdata;
  logic [NVEC-1:0] irq = '0;
  logic            msg_valid;
  logic [63:0]     msg_addr;

  msix_engine #(.NVEC(NVEC), .AW(AW)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nrecv = 0;
  bit stall = 0, done = 0;
  logic [95:0] q[$];
  logic [31:0] sh_lo [NVEC], sh_hi [NVEC], sh_dat [NVEC];

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    msg_ready = !stall;
    if (rst_n && msg_valid && msg_ready) begin
      nrecv++;
      if (q.size() == 0) check(0, "R5 unexpected message", {msg_addr, msg_data}, '0);
      else begin
        logic [95:0] e;
        e = q.pop_front();
        check({msg_addr, msg_data} == e, "R3 message content", {msg_addr, msg_data}, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = AW'(a); reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_req = 0; reg_we = 0; reg_be = 4'hF;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_addr = AW'(a); reg_be = be;
    #1 check(reg_rdata == e, tag, 96'(reg_rdata), 96'(e));
    reg_be = 4'hF;
  endtask

  task automatic cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); irq[v] = 1;
    repeat (2) @(negedge clk);
    irq[v] = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input int v);
    q.push_back({sh_hi[v], sh_lo[v] & 32'hFFFF_FFFC, sh_dat[v]});
  endtask

  task automatic set_entry(input int v, input logic [31:0] lo, hi, d);
    sh_lo[v] = lo; sh_hi[v] = hi; sh_dat[v] = d;
    wr(v*16, lo); wr(v*16+4, hi); wr(v*16+8, d);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 100 && q.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q.size() == 0, tag, 96'(q.size()), 0);
  endtask

  task automatic quiet(input string tag);
    repeat (8) @(negedge clk);
    check(!msg_valid && q.size() == 0, tag, 96'(msg_valid), 0);
  endtask

  initial begin
    int n0;
    logic [95:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    check(cfg_rdata == 16'h001F, "R1 control reset", 96'(cfg_rdata), 96'h1F);
    check(!msg_valid, "R1 valid low", 96'(msg_valid), 0);
    rd(16'h200, 0, "R1 pending zero");
    rd(16'h1FC, 0, "R1 table zero");
    // R2 layout and readback
    for (int v = 0; v < 4; v++)
      set_entry(v, 32'h1000_0003 + v*16, 32'hA0 + v, 32'hD000 + v);
    rd(2*16, 32'h1000_0023, "R2 addr low readback");
    rd(3*16+8, 32'hD003, "R2 payload readback");
    // R11 control writes
    cfg(16'hFFFF);
    check(cfg_rdata == 16'hC01F, "R11 only top bits writable", 96'(cfg_rdata), 96'hC01F);
    cfg(16'h8000);
    // R3 R5 open vector
    push(2); pulse(2); drain("R5 message delivered");
    rd(16'h200, 0, "R5 pending cleared");
    // R6 level held
    n0 = nrecv;
    push(1);
    @(negedge clk); irq[1] = 1;
    repeat (20) @(negedge clk);
    irq[1] = 0;
    drain("R6 held level");
    check(nrecv - n0 == 1, "R6 one message", 96'(nrecv - n0), 1);
    // R4 R9 R7 vector mask
    wr(3*16+12, 1);
    pulse(3);
    quiet("R4 masked vector silent");
    rd(16'h200, 32'h8, "R4 pending bit 3");
    wr(16'h200, 0);
    rd(16'h200, 32'h8, "R9 pending write ignored");
    wr(3*16+12, 0, 4'h1);
    rd(3*16+12, 1, "R9 partial write ignored");
    quiet("R9 no send on partial write");
    push(3);
    wr(3*16+12, 0);
    drain("R7 unmask sends");
    rd(16'h200, 0, "R7 pending cleared");
    // R8 function mask replay
    cfg(16'hC000);
    pulse(2); pulse(0); pulse(1);
    quiet("R4 function mask silent");
    rd(16'h200, 32'h7, "R4 pending under function mask");
    push(0); push(1); push(2);
    cfg(16'h8000);
    drain("R8 ascending replay after mask clear");
    // R8 enable replay
    cfg(16'h0000);
    pulse(1);
    quiet("R4 disabled silent");
    rd(16'h200, 32'h2, "R4 pending while disabled");
    push(1);
    cfg(16'h8000);
    drain("R8 replay after enable");
    // R12 waiting message
    stall = 1;
    n0 = nrecv;
    push(0);
    pulse(0);
    check(msg_valid == 1, "R12 message waiting", 96'(msg_valid), 1);
    held = {msg_addr, msg_data};
    pulse(0); pulse(0);
    set_entry(0, 32'h5555_0001, 32'hBB, 32'hEEEE);
    check({msg_addr, msg_data} == held, "R12 held stable", {msg_addr, msg_data}, held);
    push(0);
    stall = 0;
    drain("R12 follow-up message");
    check(nrecv - n0 == 2, "R12 two messages", 96'(nrecv - n0), 2);
    // R10 region bounds
    rd(16'h0FFC, 0, "R10 inside region past pending");
    rd(16'h1000, 32'hFFFF_FFFF, "R10 past region");
    rd(16'h0000, 32'hFFFF_FFFF, "R10 partial read", 4'h3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule